// File: doc/BRIEF.md
# Vectored Nested Interrupt Controller

This block collects up to 32 interrupt request lines and presents one interrupt output to a processor, along with a per-source vector word that software fetches over a simple register bus. Every source carries its own mode word, which sets a priority and a trigger type, and its own vector word. Software enables, disables, forces or clears sources with mask writes. It reads back the raw pending bits and the enable mask.

When the processor takes the interrupt, it reads the vector port. That read returns the vector of the highest-priority pending, enabled source, and in the same cycle it acknowledges that source: the source number and priority are pushed onto an eight-level nesting stack. From then on only sources of strictly higher priority raise the interrupt output. A write to the end-of-interrupt port pops one level. If nothing qualifies when the vector port is read, the programmed spurious vector comes back and the stack does not move.

The nesting stack is a small state machine with three states. NEST_EMPTY means no interrupt is in service. NEST_OPEN means one to seven levels are held. NEST_FULL means eight levels are held. There are four transitions. PUSH (vector read with a qualifying source) takes NEST_EMPTY to NEST_OPEN, and takes NEST_OPEN to NEST_FULL at the seventh-to-eighth level. POP (end-of-interrupt write) takes NEST_FULL to NEST_OPEN, and takes NEST_OPEN to NEST_EMPTY when the last level is released. A POP in NEST_EMPTY keeps NEST_EMPTY.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset, the enable mask, the pending bits and the nesting stack are empty, `irq_out` is low, the current-source port (0x108) reads 0, each mode word reads 0x40 (level-high, priority 0), and every vector word and the spurious word read 0.
- R2: A write to 0x120 sets the enable bits flagged in the data, a write to 0x124 clears them, and 0x110 reads the resulting enable mask.
- R3: A write to 0x12C forces the flagged sources pending and a write to 0x128 clears their latched pending state; 0x10C reads the pending bits of all sources, where a level-type source reads pending for as long as its input is at its active level, whatever clears are written.
- R4: The mode word of source n sits at byte offset 4n, with priority in bits [2:0] (7 highest) and trigger type in bits [6:5]: 0 level-low, 1 falling edge, 2 level-high, 3 rising edge; an edge-type source latches pending on the selected edge of its input.
- R5: Among pending, enabled sources the one with the greatest priority wins, ties going to the lowest source number, and a read of 0x100 returns the vector word of the winner, which is stored at byte offset 0x80 + 4n.
- R6: `irq_out` is high exactly when the winner of R5 exists and either the stack is empty or the winner's priority is strictly greater than the priority on top of the stack.
- R7: A read of 0x100 while `irq_out` is high pushes the winner onto the stack, after which 0x108 reads its source number; the read clears its latched pending bit, and a level source whose input remains active stays pending.
- R8: A source whose priority equals or is below the top-of-stack priority does not raise `irq_out` and is not delivered; a strictly higher one preempts and nests.
- R9: A read of 0x100 while `irq_out` is low returns the spurious word (written at 0x134), leaves the stack unchanged, and 0x108 keeps reading the top source, or 0 when the stack is empty.
- R10: Each write to 0x130 pops one stack level; eight levels can be held, and writes beyond the last level leave the stack empty.
- R11: In the cycle in which a source is acknowledged or cleared by a mask write, a new edge on its input or a force wins, and the source stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_in | input | 32 | Raw interrupt request lines, one per source |
| bus_sel | input | 1 | Register access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 9 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
Two functions can fall on the same source in the same clock edge. The first is the acknowledge (or a clear mask write) that removes a latched pending bit. The second is a fresh input edge that sets it again. The bench provokes this by lowering an edge source after it has latched and then raising its input on the same negative edge that presents the vector read, or the clear write, to the bus. It judges the result by reading the pending port afterwards and requiring the bit still set, as R11 demands.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;

    // Register byte offsets; software decodes these, so they are fixed.
    localparam int OFF_IVEC = 'h100;
    localparam int OFF_CUR  = 'h108;
    localparam int OFF_PEND = 'h10C;
    localparam int OFF_MASK = 'h110;
    localparam int OFF_EN   = 'h120;
    localparam int OFF_DIS  = 'h124;
    localparam int OFF_CLR  = 'h128;
    localparam int OFF_SET  = 'h12C;
    localparam int OFF_EOI  = 'h130;
    localparam int OFF_SPUR = 'h134;

    // Trigger type field of a mode word.
    typedef enum logic [1:0] {
        TRIG_LVL_LO = 2'd0,
        TRIG_FALL   = 2'd1,
        TRIG_LVL_HI = 2'd2,
        TRIG_RISE   = 2'd3
    } trig_e;

    // Occupancy state of the nesting stack.
    typedef enum logic [1:0] {
        NEST_EMPTY = 2'd0,
        NEST_OPEN  = 2'd1,
        NEST_FULL  = 2'd2
    } nest_e;

endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank
    import irq_nest_pkg::*;
#(
    parameter int NSRC = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NSRC-1:0]       src_in,
    input  logic [NSRC-1:0][1:0]  trig,
    input  logic [NSRC-1:0]       set_mask,
    input  logic [NSRC-1:0]       clr_mask,
    input  logic [NSRC-1:0]       ack_mask,
    output logic [NSRC-1:0]       pend
);

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        logic prev_q;
        logic latch_q;
        logic edge_evt;
        logic lvl_act;

        always_comb begin
            edge_evt = 1'b0;
            lvl_act  = 1'b0;
            unique case (trig_e'(trig[g]))
                TRIG_LVL_LO: lvl_act  = ~src_in[g];
                TRIG_FALL:   edge_evt = prev_q & ~src_in[g];
                TRIG_LVL_HI: lvl_act  = src_in[g];
                TRIG_RISE:   edge_evt = ~prev_q & src_in[g];
            endcase
        end

        // A new edge or a force overrides a clear or an acknowledge in the same cycle.
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                prev_q  <= 1'b0;
                latch_q <= 1'b0;
            end else begin
                prev_q  <= src_in[g];
                latch_q <= (latch_q & ~clr_mask[g] & ~ack_mask[g]) | edge_evt | set_mask[g];
            end
        end

        assign pend[g] = latch_q | lvl_act;

        AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            (edge_evt || set_mask[g]) |=> pend[g]); // R11
    end

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
    parameter int NSRC   = 32,
    parameter int PRIO_W = 3,
    localparam int SRC_W = $clog2(NSRC)
) (
    input  logic [NSRC-1:0]             cand,
    input  logic [NSRC-1:0][PRIO_W-1:0] prio,
    output logic                        found,
    output logic [SRC_W-1:0]            win_idx,
    output logic [PRIO_W-1:0]           win_prio
);

    // Strictly-greater update keeps the lowest index on a tie.
    always_comb begin
        found    = 1'b0;
        win_idx  = '0;
        win_prio = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (cand[i] && (!found || prio[i] > win_prio)) begin
                found    = 1'b1;
                win_idx  = SRC_W'(i);
                win_prio = prio[i];
            end
        end
    end

endmodule

// File: rtl/irq_nest_stack.sv
module irq_nest_stack
    import irq_nest_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int SRC_W  = 5,
    parameter int PRIO_W = 3,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    input  logic [SRC_W-1:0]  push_src,
    input  logic [PRIO_W-1:0] push_prio,
    output logic              empty,
    output logic [SRC_W-1:0]  top_src,
    output logic [PRIO_W-1:0] top_prio,
    output logic [CNT_W-1:0]  level
);

    nest_e             state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [SRC_W-1:0]  src_q  [DEPTH];
    logic [PRIO_W-1:0] prio_q [DEPTH];
    logic              do_push, do_pop;
    logic [CNT_W-1:0]  top_idx;

    assign do_push = push && (state_q != NEST_FULL);
    assign do_pop  = pop  && (state_q != NEST_EMPTY);

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= NEST_EMPTY;
        else        state_q <= state_d;
    end

    // Transitions: PUSH and POP.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            NEST_EMPTY: if (do_push) state_d = (DEPTH == 1) ? NEST_FULL : NEST_OPEN;
            NEST_OPEN: begin
                if (do_push && cnt_q == CNT_W'(DEPTH - 1)) state_d = NEST_FULL;
                else if (do_pop && cnt_q == CNT_W'(1))     state_d = NEST_EMPTY;
            end
            NEST_FULL:  if (do_pop) state_d = (DEPTH == 1) ? NEST_EMPTY : NEST_OPEN;
            default:    state_d = NEST_EMPTY;
        endcase
    end

    // Stack storage and level counter.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                src_q[i]  <= '0;
                prio_q[i] <= '0;
            end
        end else if (do_push) begin
            src_q[cnt_q]  <= push_src;
            prio_q[cnt_q] <= push_prio;
            cnt_q         <= cnt_q + CNT_W'(1);
        end else if (do_pop) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    // Outputs.
    always_comb begin
        empty    = (state_q == NEST_EMPTY);
        top_idx  = empty ? '0 : cnt_q - CNT_W'(1);
        top_src  = src_q[top_idx];
        top_prio = prio_q[top_idx];
        level    = cnt_q;
    end

    AST_NO_OVERFLOW:   assert property (@(posedge clk) disable iff (!rst_n)
        push |-> state_q != NEST_FULL); // R10
    AST_UNDERFLOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && state_q == NEST_EMPTY) |=> state_q == NEST_EMPTY); // R10
    AST_PUSH_STEP:     assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |=> cnt_q == $past(cnt_q) + CNT_W'(1)); // R7
    AST_STATE_COUNT:   assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == NEST_EMPTY) == (cnt_q == '0)); // R10

endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
    import irq_nest_pkg::*;
#(
    parameter int NSRC   = 32,
    parameter int PRIO_W = 3,
    parameter int DEPTH  = 8,
    parameter int DW     = 32,
    parameter int AW     = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_in,
    input  logic            bus_sel,
    input  logic            bus_wr,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    output logic            irq_out
);

    localparam int SRC_W = $clog2(NSRC);
    localparam int RGN_W = AW - SRC_W - 2;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [NSRC-1:0][PRIO_W-1:0] mode_prio;
    logic [NSRC-1:0][1:0]        mode_trig;
    logic [DW-1:0]               vec_q [NSRC];
    logic [NSRC-1:0]             en_q;
    logic [DW-1:0]               spur_q;

    logic              wr_hit, rd_vec;
    logic [RGN_W-1:0]  region;
    logic [SRC_W-1:0]  idx;
    logic              in_mode, in_vec;
    logic [NSRC-1:0]   set_mask, clr_mask, ack_mask, pend;
    logic              found, qualify, push, pop;
    logic [SRC_W-1:0]  win_idx, top_src;
    logic [PRIO_W-1:0] win_prio, top_prio;
    logic              empty;
    logic [CNT_W-1:0]  level;

    // Address decode.
    assign wr_hit  = bus_sel && bus_wr;
    assign region  = bus_addr[AW-1:SRC_W+2];
    assign idx     = bus_addr[SRC_W+1:2];
    assign in_mode = (region == RGN_W'(0));
    assign in_vec  = (region == RGN_W'(1));
    assign rd_vec  = bus_sel && !bus_wr && (bus_addr == AW'(OFF_IVEC));
    assign pop     = wr_hit && (bus_addr == AW'(OFF_EOI));

    assign set_mask = (wr_hit && bus_addr == AW'(OFF_SET)) ? bus_wdata[NSRC-1:0] : '0;
    assign clr_mask = (wr_hit && bus_addr == AW'(OFF_CLR)) ? bus_wdata[NSRC-1:0] : '0;

    // Configuration registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= '0;
            spur_q <= '0;
            for (int i = 0; i < NSRC; i++) begin
                mode_prio[i] <= '0;
                mode_trig[i] <= TRIG_LVL_HI;
                vec_q[i]     <= '0;
            end
        end else if (wr_hit) begin
            if (in_mode) begin
                mode_prio[idx] <= bus_wdata[PRIO_W-1:0];
                mode_trig[idx] <= bus_wdata[6:5];
            end else if (in_vec) begin
                vec_q[idx] <= bus_wdata;
            end else if (bus_addr == AW'(OFF_EN)) begin
                en_q <= en_q | bus_wdata[NSRC-1:0];
            end else if (bus_addr == AW'(OFF_DIS)) begin
                en_q <= en_q & ~bus_wdata[NSRC-1:0];
            end else if (bus_addr == AW'(OFF_SPUR)) begin
                spur_q <= bus_wdata;
            end
        end
    end

    irq_src_bank #(.NSRC(NSRC)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_in   (src_in),
        .trig     (mode_trig),
        .set_mask (set_mask),
        .clr_mask (clr_mask),
        .ack_mask (ack_mask),
        .pend     (pend)
    );

    irq_arbiter #(.NSRC(NSRC), .PRIO_W(PRIO_W)) u_arb (
        .cand     (pend & en_q),
        .prio     (mode_prio),
        .found    (found),
        .win_idx  (win_idx),
        .win_prio (win_prio)
    );

    assign qualify = found && (empty || win_prio > top_prio);
    assign push    = rd_vec && qualify;

    always_comb begin
        ack_mask = '0;
        if (push) ack_mask[win_idx] = 1'b1;
    end

    irq_nest_stack #(.DEPTH(DEPTH), .SRC_W(SRC_W), .PRIO_W(PRIO_W)) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .pop       (pop),
        .push_src  (win_idx),
        .push_prio (win_prio),
        .empty     (empty),
        .top_src   (top_src),
        .top_prio  (top_prio),
        .level     (level)
    );

    assign irq_out = qualify;

    // Read mux.
    always_comb begin
        bus_rdata = '0;
        if (in_mode) begin
            bus_rdata = DW'({mode_trig[idx], 2'b00, mode_prio[idx]});
        end else if (in_vec) begin
            bus_rdata = vec_q[idx];
        end else if (bus_addr == AW'(OFF_IVEC)) begin
            bus_rdata = qualify ? vec_q[win_idx] : spur_q;
        end else if (bus_addr == AW'(OFF_CUR)) begin
            bus_rdata = empty ? '0 : DW'(top_src);
        end else if (bus_addr == AW'(OFF_PEND)) begin
            bus_rdata = DW'(pend);
        end else if (bus_addr == AW'(OFF_MASK)) begin
            bus_rdata = DW'(en_q);
        end else if (bus_addr == AW'(OFF_SPUR)) begin
            bus_rdata = spur_q;
        end
    end

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> |(pend & en_q)); // R6
    AST_PUSH_RECORDS:     assert property (@(posedge clk) disable iff (!rst_n)
        push |=> (!empty && top_src == $past(win_idx) && top_prio == $past(win_prio))); // R7
    AST_SPUR_NO_PUSH:     assert property (@(posedge clk) disable iff (!rst_n)
        (rd_vec && !irq_out) |=> $stable(level)); // R9
    AST_NEST_RAISES:      assert property (@(posedge clk) disable iff (!rst_n)
        (push && !empty) |=> top_prio > $past(top_prio)); // R8

endmodule

// File: tb/sim_irq_nest_ctrl.sv
module sim_irq_nest_ctrl;
    import irq_nest_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_in = '0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [8:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_out;

    always #10 clk = ~clk;   // 50 MHz

    irq_nest_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .src_in(src_in), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;
    localparam logic [31:0] SPUR = 32'h5A5A_0F0F;

    // Bench model for the random phase.
    logic [31:0] m_pend, m_en;
    int m_prio [32];
    int st_prio [8];
    int st_src [8];
    int m_cnt;

    function automatic logic [31:0] vec_of(int n);
        return 32'hA500_0000 | n;
    endfunction

    function automatic int m_win();
        int best = -1;
        for (int i = 0; i < 32; i++)
            if (m_pend[i] && m_en[i] && (best < 0 || m_prio[i] > m_prio[best])) best = i;
        if (best >= 0 && m_cnt > 0 && m_prio[best] <= st_prio[m_cnt-1]) best = -1;
        return best;
    endfunction

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = 9'(a); bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
        #1;
    endtask

    task automatic rd(int a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = 9'(a);
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 0;
        #1;
    endtask

    task automatic tick();
        @(negedge clk); #1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int seed;
        seed = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;

        // R1 reset state
        chk("R1 irq", {31'd0, irq_out}, 0);
        rd(OFF_MASK, d); chk("R1 mask", d, 0);
        rd(OFF_PEND, d); chk("R1 pend", d, 0);
        rd(OFF_CUR, d);  chk("R1 cur", d, 0);
        rd(5*4, d);      chk("R1 mode", d, 32'h40);
        rd('h80 + 3*4, d); chk("R1 vec", d, 0);
        rd(OFF_SPUR, d); chk("R1 spur", d, 0);

        for (int i = 0; i < 32; i++) wr('h80 + 4*i, vec_of(i));
        wr(OFF_SPUR, SPUR);
        rd('h80 + 4*17, d); chk("R5 vec readback", d, vec_of(17));

        // R2 enable / disable
        wr(OFF_EN, 32'hF0); wr(OFF_DIS, 32'h30);
        rd(OFF_MASK, d); chk("R2 mask", d, 32'hC0);
        wr(OFF_DIS, 32'hFFFF_FFFF);

        // R3 level-high source and software force
        src_in[4] = 1; tick();
        rd(OFF_PEND, d); chk("R3 level pend", d, 32'h10);
        wr(OFF_CLR, 32'h10);
        rd(OFF_PEND, d); chk("R3 level ignores clear", d, 32'h10);
        src_in[4] = 0; tick();
        rd(OFF_PEND, d); chk("R3 level drop", d, 0);
        wr(OFF_SET, 32'h200);
        rd(OFF_PEND, d); chk("R3 force", d, 32'h200);
        wr(OFF_CLR, 32'h200);
        rd(OFF_PEND, d); chk("R3 clear", d, 0);

        // R4 trigger types
        wr(2*4, 32'h00);                          // level-low
        rd(2*4, d); chk("R4 mode readback", d, 0);
        rd(OFF_PEND, d); chk("R4 level-low active", d, 32'h4);
        src_in[2] = 1; tick();
        rd(OFF_PEND, d); chk("R4 level-low idle", d, 0);
        wr(6*4, 32'h60);                          // rising
        src_in[6] = 1; tick(); src_in[6] = 0; tick();
        rd(OFF_PEND, d); chk("R4 rising latched", d, 32'h40);
        wr(OFF_CLR, 32'h40);
        wr(7*4, 32'h20);                          // falling
        src_in[7] = 1; tick();
        rd(OFF_PEND, d); chk("R4 falling no rise", d, 0);
        src_in[7] = 0; tick();
        rd(OFF_PEND, d); chk("R4 falling latched", d, 32'h80);
        wr(OFF_CLR, 32'h80);
        src_in[2] = 0; wr(2*4, 32'h40);

        // R5 / R7 / R8 / R9 arbitration and nesting
        wr(10*4, 32'h65); wr(11*4, 32'h63); wr(12*4, 32'h65); wr(13*4, 32'h66);
        wr(OFF_EN, 32'h1C00);
        wr(OFF_SET, 32'h1C00);
        chk("R6 irq up", {31'd0, irq_out}, 1);
        rd(OFF_IVEC, d); chk("R5 tie lowest", d, vec_of(10));
        rd(OFF_CUR, d);  chk("R7 cur", d, 10);
        rd(OFF_PEND, d); chk("R7 ack clears edge", d, 32'h1800);
        chk("R8 equal blocked", {31'd0, irq_out}, 0);
        wr(OFF_EN, 32'h2000); wr(OFF_SET, 32'h2000);
        chk("R8 higher preempts", {31'd0, irq_out}, 1);
        rd(OFF_IVEC, d); chk("R8 nested vec", d, vec_of(13));
        rd(OFF_CUR, d);  chk("R8 nested cur", d, 13);
        wr(OFF_EOI, 0);
        rd(OFF_CUR, d);  chk("R10 pop", d, 10);
        chk("R8 still blocked", {31'd0, irq_out}, 0);
        wr(OFF_EOI, 0);
        chk("R6 irq after unwind", {31'd0, irq_out}, 1);
        rd(OFF_IVEC, d); chk("R5 next", d, vec_of(12));
        wr(OFF_EOI, 0);
        rd(OFF_IVEC, d); chk("R5 low prio", d, vec_of(11));
        wr(OFF_EOI, 0);
        rd(OFF_IVEC, d); chk("R9 spurious", d, SPUR);
        rd(OFF_CUR, d);  chk("R9 cur zero", d, 0);
        chk("R9 irq low", {31'd0, irq_out}, 0);

        // R7 level source stays pending after acknowledge
        wr(4*4, 32'h42); wr(OFF_EN, 32'h10);
        src_in[4] = 1; tick();
        rd(OFF_IVEC, d); chk("R7 level vec", d, vec_of(4));
        rd(OFF_PEND, d); chk("R7 level still pending", d, 32'h10);
        wr(OFF_EOI, 0); src_in[4] = 0; wr(OFF_DIS, 32'hFFFF_FFFF);

        // R10 eight-level nesting and extra end-of-interrupt writes
        for (int p = 0; p < 8; p++) wr((16+p)*4, 32'h60 | p);
        wr(OFF_EN, 32'h00FF_0000);
        for (int p = 0; p < 8; p++) begin
            wr(OFF_SET, 32'h1 << (16+p));
            rd(OFF_IVEC, d); chk("R10 nest vec", d, vec_of(16+p));
        end
        rd(OFF_CUR, d); chk("R10 full top", d, 23);
        chk("R10 full irq", {31'd0, irq_out}, 0);
        for (int k = 0; k < 7; k++) wr(OFF_EOI, 0);
        rd(OFF_CUR, d); chk("R10 bottom", d, 16);
        wr(OFF_EOI, 0); wr(OFF_EOI, 0);
        rd(OFF_CUR, d); chk("R10 empty after extra", d, 0);
        wr(OFF_SET, 32'h1_0000);
        chk("R10 stack usable", {31'd0, irq_out}, 1);
        rd(OFF_IVEC, d); chk("R10 after unwind", d, vec_of(16));
        wr(OFF_EOI, 0);

        // R11 edge in the acknowledge cycle
        wr(24*4, 32'h64); wr(OFF_EN, 32'h0100_0000);
        src_in[24] = 1; tick(); src_in[24] = 0; tick();
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = 9'(OFF_IVEC); src_in[24] = 1;
        #1 d = bus_rdata;
        @(negedge clk); bus_sel = 0; #1;
        chk("R11 ack vec", d, vec_of(24));
        rd(OFF_PEND, d); chk("R11 edge beats ack", d, 32'h0100_0000);
        wr(OFF_EOI, 0);
        // R11 edge in the clear cycle
        wr(25*4, 32'h61);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = 9'(OFF_CLR); bus_wdata = 32'h0300_0000; src_in[25] = 1;
        @(negedge clk); bus_sel = 0; bus_wr = 0; #1;
        rd(OFF_PEND, d); chk("R11 edge beats clear", d, 32'h0200_0000);

        // Clean up before random phase
        src_in = '0; tick();
        wr(OFF_CLR, 32'hFFFF_FFFF); wr(OFF_DIS, 32'hFFFF_FFFF);
        for (int k = 0; k < 8; k++) wr(OFF_EOI, 0);
        for (int i = 0; i < 32; i++) begin
            m_prio[i] = $urandom % 8;
            wr(i*4, 32'h60 | m_prio[i]);
        end
        m_pend = '0; m_en = '0; m_cnt = 0;

        // Constrained random phase
        for (int it = 0; it < 500; it++) begin
            int op;
            logic [31:0] m;
            op = $urandom % 6;
            m  = $urandom & $urandom & $urandom;
            unique case (op)
                0: begin wr(OFF_SET, m); m_pend |= m; end
                1: begin wr(OFF_CLR, m); m_pend &= ~m; end
                2: begin wr(OFF_EN, m);  m_en |= m; end
                3: begin wr(OFF_DIS, m); m_en &= ~m; end
                4: begin
                    int w;
                    w = m_win();
                    rd(OFF_IVEC, d);
                    if (w >= 0) begin
                        chk("R5 random vec", d, vec_of(w));
                        m_pend[w] = 1'b0;
                        st_prio[m_cnt] = m_prio[w];
                        st_src[m_cnt]  = w;
                        m_cnt++;
                    end else begin
                        chk("R9 random spurious", d, SPUR);
                    end
                end
                default: begin wr(OFF_EOI, 0); if (m_cnt > 0) m_cnt--; end
            endcase
            chk("R6 random irq", {31'd0, irq_out}, {31'd0, m_win() >= 0});
            if (it % 25 == 0) begin
                rd(OFF_PEND, d); chk("R3 random pend", d, m_pend);
                rd(OFF_MASK, d); chk("R2 random mask", d, m_en);
                rd(OFF_CUR, d);  chk("R7 random cur", d, m_cnt > 0 ? st_src[m_cnt-1] : 0);
            end
        end

        done = 1;
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule